// File: doc/BRIEF.md
# Non-Overlapping 101 Pattern Counter

This combinational block takes a 32-bit word and returns how many `101` bit patterns it holds. The count follows a non-overlap rule that favours the higher-order bits. Each bit position that could start a pattern has its own detector. A start position is named after the most significant of its three bits. A detector raises a flag when its three bits read `101`. It drops a pattern whose leading 1 is the trailing 1 of a `101` that starts two positions higher. The decision uses only the two bits directly above the pattern.

The flags are split into 4-bit groups. Each group produces a small ones count, and a balanced adder tree sums the group counts into a 6-bit result. The block has no clock and no state. The result settles one propagation delay after the word changes, so a neighbouring stage can register it in the same cycle the word arrives.

Top module: `p101_counter`

## Requirements
- R1: `count_o` equals the number of start positions that flag under R2 to R4. It is an unsigned 6-bit value.
- R2: For a start position p from 2 to 29, the flag is set when word bits p, p-1 and p-2 read 1, 0, 1 and also bit p+1 is 1 or bit p+2 is 0.
- R3: Start positions 31 and 30 flag whenever their three bits read 1, 0, 1, with no condition on higher bits.
- R4: Start positions 1 and 0 never flag; for example, 0x00000003 counts 0 and 0x00000005 counts 1.
- R5: The all-zeros word and the all-ones word both count 0.
- R6: A `101` whose leading 1 is also the last 1 of a `101` starting two positions higher is not counted. 0x00000015 counts 1, 0xAAAAAAAA counts 1 and 0x55555555 counts 1.
- R7: A 1 directly above a pattern qualifies it whatever lies two above. 0x0000002D counts 2 and 0x000000ED counts 2.
- R8: The output is a pure function of the present input. It changes with no clock edge and does not depend on earlier inputs.
- R9: Two flags are never one or two positions apart. As a result, `count_o` never exceeds 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | 32 | Word to scan; bit 31 is the highest-priority end |
| count_o | output | 6 | Number of counted `101` patterns |

## Verification
The in-RTL assertions are evaluated on every input change. They check that flags never sit one or two positions apart, and that each group count stays within its group size. They also check that the tree sum agrees with the ones count of the flag vector, and that the total stays within the bound of R9. The assertions cannot show whether the right positions flag. The rule at the top and bottom ends, the F-versus-G qualification and the reference examples need the bench's directed vectors and its comparison against an independent model on random words. Independence from earlier inputs is shown by reapplying vectors in a different order.

// File: rtl/p101_pkg.sv
package p101_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned GRP_W  = 4;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
  localparam int unsigned GSUM_W = $clog2(GRP_W + 1);
  localparam int unsigned N_GRP  = WORD_W / GRP_W;
endpackage

// File: rtl/p101_flag_detect.sv
module p101_flag_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] flag_o
);
  for (genvar p = 0; p < WIDTH; p++) begin : g_pos
    if (p >= WIDTH - 2) begin : g_top
      // no two bits above: bare 101 match
      assign flag_o[p] = word_i[p] & ~word_i[p-1] & word_i[p-2];
    end else if (p >= 2) begin : g_mid
      // skip when bits above are 10, i.e. our leading 1 ends a higher 101
      assign flag_o[p] = word_i[p] & ~word_i[p-1] & word_i[p-2]
                       & (word_i[p+1] | ~word_i[p+2]);
    end else begin : g_low
      assign flag_o[p] = 1'b0;
    end
  end

  always_comb begin
    for (int p = 0; p + 1 < WIDTH; p++) begin
      assert_no_adjacent_flags_R9: assert (!(flag_o[p] && flag_o[p+1]))
        else $error("adjacent flags at %0d", p);
    end
    for (int p = 0; p + 2 < WIDTH; p++) begin
      assert_no_overlap_R6: assert (!(flag_o[p] && flag_o[p+2]))
        else $error("overlapping flags at %0d", p);
    end
  end
endmodule

// File: rtl/p101_group_count.sv
module p101_group_count #(
  parameter int unsigned GRP   = 4,
  parameter int unsigned SUM_W = $clog2(GRP + 1)
) (
  input  logic [GRP-1:0]   bits_i,
  output logic [SUM_W-1:0] sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < GRP; i++) sum_o = sum_o + SUM_W'(bits_i[i]);
  end

  always_comb begin
    assert_group_range_R1: assert (32'(sum_o) <= GRP)
      else $error("group sum %0d exceeds %0d", sum_o, GRP);
  end
endmodule

// File: rtl/p101_sum_tree.sv
module p101_sum_tree #(
  parameter int unsigned N     = 8,   // power of two
  parameter int unsigned IN_W  = 3,
  parameter int unsigned OUT_W = 6
) (
  input  logic [N*IN_W-1:0] leaves_i,
  output logic [OUT_W-1:0]  sum_o
);
  localparam int unsigned NODES = 2 * N - 1;

  logic [OUT_W-1:0] node [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[N-1+i] = OUT_W'(leaves_i[i*IN_W +: IN_W]);
  end

  for (genvar i = 0; i + 1 < N; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum_o = node[0];
endmodule

// File: rtl/p101_counter.sv
module p101_counter
  import p101_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [WORD_W-1:0]       flag;
  logic [N_GRP*GSUM_W-1:0] grp_sum;

  p101_flag_detect #(.WIDTH(WORD_W)) u_detect (
    .word_i (word_i),
    .flag_o (flag)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    p101_group_count #(.GRP(GRP_W), .SUM_W(GSUM_W)) u_grp (
      .bits_i (flag[g*GRP_W +: GRP_W]),
      .sum_o  (grp_sum[g*GSUM_W +: GSUM_W])
    );
  end

  p101_sum_tree #(.N(N_GRP), .IN_W(GSUM_W), .OUT_W(CNT_W)) u_tree (
    .leaves_i (grp_sum),
    .sum_o    (count_o)
  );

  always_comb begin
    assert_count_matches_flags_R1: assert (32'(count_o) == $countones(flag))
      else $error("tree sum %0d vs flags %0d", count_o, $countones(flag));
    assert_count_bound_R9: assert (32'(count_o) <= WORD_W / 3)
      else $error("count %0d above bound", count_o);
  end
endmodule

// File: tb/tb_p101_counter.sv
module tb_p101_counter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word;
  logic [5:0]  count;
  int          n_run = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  p101_counter dut (.word_i(word), .count_o(count));

  // {word, expected count}
  localparam logic [37:0] VEC [14] = '{
    {32'h0000_0000, 6'd0},  // R5
    {32'hFFFF_FFFF, 6'd0},  // R5
    {32'hAAAA_AAAA, 6'd1},  // R6, R3
    {32'h5555_5555, 6'd1},  // R6, R3
    {32'hA900_0000, 6'd1},  // R3, R6
    {32'h0000_0005, 6'd1},  // R4, R2
    {32'h0000_0003, 6'd0},  // R4
    {32'h0000_000B, 6'd1},  // R2
    {32'h0000_00A5, 6'd2},  // R2
    {32'h0000_0015, 6'd1},  // R6
    {32'h0000_002D, 6'd2},  // R7
    {32'h0000_00ED, 6'd2},  // R7
    {32'hB000_0000, 6'd1},  // R3
    {32'h6DB6_DB6D, 6'd10}  // R9 max
  };

  function automatic int model(input logic [31:0] w);
    int n = 0;
    for (int p = 31; p >= 2; p--) begin
      bit hit = (w[p] == 1'b1) && (w[p-1] == 1'b0) && (w[p-2] == 1'b1);
      if (hit && p <= 29 && w[p+1] == 1'b0 && w[p+2] == 1'b1) hit = 0;
      if (hit) n++;
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] w, input int exp);
    word = w;
    #3;
    n_run++;
    if (int'(count) != exp) begin
      n_fail++;
      $display("FAIL %s word=%h actual=%0d expected=%0d", req, w, count, exp);
    end
  endtask

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  initial begin
    wait (cyc == 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    word = 32'h0;
    #25 rst_ni = 1'b1;
    // reset-state style check: idle input gives zero (R5)
    check("R5", 32'h0, 0);
    for (int i = 0; i < 14; i++)
      check("R1", VEC[i][37:6], int'(VEC[i][5:0]));
    // reverse order: no memory of earlier inputs (R8)
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk);
      check("R8", VEC[i][37:6], int'(VEC[i][5:0]));
    end
    // position 1 and 0 alone cannot start a pattern (R4)
    check("R4", 32'h0000_0002, 0);
    check("R4", 32'h0000_0001, 0);
    // top pair with higher-bit qualifier absent (R3)
    check("R3", 32'h5000_0000, 1);
    // random words against model (R2)
    for (int i = 0; i < 500; i++) begin
      logic [31:0] w = $urandom();
      @(negedge clk);
      check("R2", w, model(w));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule